// File: doc/BRIEF.md
# Debug-Loaded Locked Instruction Cache

This block is a small two-way set-associative instruction store that holds code placed there by a debugger. Normal instruction fetches only look it up: a fetch that misses never brings a line in. Lines arrive only as whole lines through a debug download port, so application code cannot displace them. Only another debug download can replace a line that is already held.

Three ports share the arrays. The fetch port takes a word address and returns a hit flag and the selected word one cycle later. The debug port loads a full line, invalidates one line by address, or clears the whole store. The maintenance port lets application software invalidate one line by address. A global invalidate from software is accepted on that port but does nothing. A processor reset empties the store only when neither halt mode nor load mode is active. Otherwise the contents, and debug commands issued during reset, carry through the reset.

Top module: `locked_icache`

## Requirements
- R1: A byte address splits into word offset bits [4:2], set index bits [9:5] and tag bits [31:10]. The fetch port takes address bits [31:2]. The debug and maintenance ports take line address bits [31:5]. Word i of a loaded line is taken from `dbg_line[32*i+31:32*i]`, and a fetch of any word of a loaded line returns that word.
- R2: `fetch_vld` is high in exactly the cycle after a cycle with `fetch_req` high. On a miss `fetch_hit` is 0 and `fetch_data` is 0.
- R3: A fetch that misses changes no state, and a repeated fetch to the same address still misses.
- R4: Each set has a round-robin pointer that starts at way 0. A debug load whose tag misses in its set writes the way the pointer names, then advances the pointer. The choice does not depend on which ways are valid.
- R5: A debug load whose tag already hits in its set overwrites that way in place and leaves the pointer unchanged. A tag is never held in two ways of one set.
- R6: A maintenance line invalidate (`sw_op` = 1) to an address that hits clears that line. One that misses has no effect.
- R7: A maintenance global invalidate (`sw_op` = 2) and `sw_op` = 3 change no state.
- R8: Debug `dbg_cmd` = 2 invalidates the line that hits at `dbg_addr`. Debug `dbg_cmd` = 3 clears every line. `dbg_cmd` = 1 loads a line and 0 is idle.
- R9: While `rst_n` is low with `halt_mode` and `load_mode` both low, all lines and pointers are cleared. With either mode high, the stored contents survive the reset.
- R10: A fetch issued in the same cycle as a debug command to the same set, or a debug global clear, reports a miss. Fetches to other sets are unaffected.
- R11: A maintenance request in the same cycle as any debug command is ignored. So is a maintenance request while `rst_n` is low.
- R12: Debug commands take effect while `rst_n` is low if `halt_mode` or `load_mode` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low processor reset |
| halt_mode | input | 1 | Processor is halted for debug |
| load_mode | input | 1 | Debug download mode is active |
| fetch_req | input | 1 | Fetch lookup request |
| fetch_waddr | input | 30 | Fetch word address (byte address bits 31:2) |
| fetch_vld | output | 1 | Lookup result present |
| fetch_hit | output | 1 | Lookup hit |
| fetch_data | output | 32 | Selected word on hit, zero on miss |
| dbg_cmd | input | 2 | 0 idle, 1 load line, 2 invalidate line, 3 clear all |
| dbg_laddr | input | 27 | Debug line address (byte address bits 31:5) |
| dbg_line | input | 256 | Line data for a load, word 0 in the low bits |
| sw_op | input | 2 | 0 idle, 1 invalidate line, 2 global invalidate (no effect), 3 no effect |
| sw_laddr | input | 27 | Maintenance line address (byte address bits 31:5) |

## Verification
The hardest conditions to reach from the ports are a pointer that has been held back by an in-place overwrite, and contents that must survive a reset. The stimulus table loads three tags into one set and reloads a tag that is already present. It then loads a fourth tag: the victim shows whether the pointer moved. The directed part issues resets with each mode setting and issues debug loads during reset. It also places a debug load or a debug invalidate in the same cycle as a fetch or a maintenance request, to exercise each priority rule.

// File: rtl/icl_pkg.sv
// Package: shared command encodings for the locked instruction cache.
// Assumes: two-bit command fields on the debug and maintenance ports.
package icl_pkg;

    typedef enum logic [1:0] {
        DBG_IDLE     = 2'd0,
        DBG_LOAD     = 2'd1,
        DBG_INV_LINE = 2'd2,
        DBG_INV_ALL  = 2'd3
    } dbg_cmd_e;

    typedef enum logic [1:0] {
        SW_IDLE     = 2'd0,
        SW_INV_LINE = 2'd1,
        SW_INV_ALL  = 2'd2,
        SW_RSVD     = 2'd3
    } sw_op_e;

endpackage

// File: rtl/icl_tag_store.sv
// Module: tag, valid and round-robin state for every set and way.
// Does: three parallel tag lookups (fetch, debug, maintenance), one line
//       write, one line invalidate, a global clear and a conditional reset clear.
// Assumes: at most one write and one invalidate per cycle, chosen by icl_ctrl.
module icl_tag_store #(
    parameter int SETS  = 32,
    parameter int WAYS  = 2,
    parameter int TAG_W = 22,
    parameter int IDX_W = 5,
    parameter int WAY_W = 1,
    parameter int PORTS = 3
) (
    input  logic                        clk,
    input  logic                        clr,
    input  logic [PORTS-1:0][IDX_W-1:0] q_idx,
    input  logic [PORTS-1:0][TAG_W-1:0] q_tag,
    output logic [PORTS-1:0][WAYS-1:0]  q_hit,
    output logic [WAY_W-1:0]            q_rr,
    input  logic                        wr_en,
    input  logic [IDX_W-1:0]            wr_idx,
    input  logic [WAY_W-1:0]            wr_way,
    input  logic [TAG_W-1:0]            wr_tag,
    input  logic                        rr_adv,
    input  logic                        inv_en,
    input  logic [IDX_W-1:0]            inv_idx,
    input  logic [WAY_W-1:0]            inv_way,
    input  logic                        inv_all,
    output logic [SETS*WAYS-1:0]        valid_flat
);

    localparam logic [WAY_W-1:0] LAST_WAY = WAY_W'(WAYS - 1);

    logic [TAG_W-1:0]           tag_q   [SETS][WAYS];
    logic [SETS-1:0][WAYS-1:0]  valid_q;
    logic [WAY_W-1:0]           rr_q    [SETS];

    // Tag array write; tags need no reset because valid bits gate them.
    always_ff @(posedge clk) begin
        if (wr_en) tag_q[wr_idx][wr_way] <= wr_tag;
    end

    // Valid bits: reset clear, global clear, then line invalidate and line write.
    always_ff @(posedge clk) begin
        if (clr || inv_all) begin
            valid_q <= '0;
        end else begin
            if (inv_en) valid_q[inv_idx][inv_way] <= 1'b0;
            if (wr_en)  valid_q[wr_idx][wr_way]   <= 1'b1;
        end
    end

    // Round-robin pointers: cleared with the store, stepped on a missing load.
    always_ff @(posedge clk) begin
        if (clr) begin
            for (int s = 0; s < SETS; s++) rr_q[s] <= '0;
        end else if (rr_adv) begin
            rr_q[wr_idx] <= (rr_q[wr_idx] == LAST_WAY) ? '0 : rr_q[wr_idx] + 1'b1;
        end
    end

    // Parallel compare for every lookup port and way.
    for (genvar p = 0; p < PORTS; p++) begin : g_port
        for (genvar w = 0; w < WAYS; w++) begin : g_way
            assign q_hit[p][w] = valid_q[q_idx[p]][w] &&
                                 (tag_q[q_idx[p]][w] == q_tag[p]);
        end
    end

    // Pointer of the set addressed on lookup port 1 (the debug port).
    assign q_rr       = rr_q[q_idx[1]];
    assign valid_flat = valid_q;

endmodule

// File: rtl/icl_data_store.sv
// Module: line data array, written a whole line at a time.
// Does: one line write per cycle, read of one word from every way of a set.
// Assumes: the caller selects the way by the tag hit vector.
module icl_data_store #(
    parameter int SETS   = 32,
    parameter int WAYS   = 2,
    parameter int WORDS  = 8,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 5,
    parameter int WAY_W  = 1,
    parameter int OFF_W  = 3
) (
    input  logic                          clk,
    input  logic                          wr_en,
    input  logic [IDX_W-1:0]              wr_idx,
    input  logic [WAY_W-1:0]              wr_way,
    input  logic [WORDS*DATA_W-1:0]       wr_line,
    input  logic [IDX_W-1:0]              rd_idx,
    input  logic [OFF_W-1:0]              rd_off,
    output logic [WAYS-1:0][DATA_W-1:0]   rd_word
);

    logic [WORDS*DATA_W-1:0] line_q [SETS][WAYS];

    // Whole-line write from the debug port.
    always_ff @(posedge clk) begin
        if (wr_en) line_q[wr_idx][wr_way] <= wr_line;
    end

    // Word select in every way of the addressed set.
    for (genvar w = 0; w < WAYS; w++) begin : g_rd
        assign rd_word[w] = line_q[rd_idx][w][rd_off*DATA_W +: DATA_W];
    end

endmodule

// File: rtl/icl_ctrl.sv
// Module: command arbitration and victim selection.
// Does: turns debug and maintenance requests plus lookup hits into array
//       writes and invalidates; debug wins over maintenance.
// Assumes: hit vectors hold at most one set bit.
module icl_ctrl
    import icl_pkg::*;
#(
    parameter int WAYS  = 2,
    parameter int IDX_W = 5,
    parameter int WAY_W = 1
) (
    input  logic              rst_n,
    input  logic              hold,
    input  dbg_cmd_e          dbg_cmd,
    input  logic [IDX_W-1:0]  dbg_idx,
    input  logic [WAYS-1:0]   dbg_hit,
    input  logic [WAY_W-1:0]  dbg_rr,
    input  sw_op_e            sw_op,
    input  logic [IDX_W-1:0]  sw_idx,
    input  logic [WAYS-1:0]   sw_hit,
    output logic              clr,
    output logic              wr_en,
    output logic [WAY_W-1:0]  wr_way,
    output logic              rr_adv,
    output logic              inv_en,
    output logic [IDX_W-1:0]  inv_idx,
    output logic [WAY_W-1:0]  inv_way,
    output logic              inv_all
);

    logic             dbg_ok;
    logic             sw_ok;
    logic             dbg_any;
    logic             sw_any;
    logic [WAY_W-1:0] dbg_way;
    logic [WAY_W-1:0] sw_way;

    // Reset empties the store only outside halt and load modes.
    assign clr    = !rst_n && !hold;
    assign dbg_ok = !clr;
    assign sw_ok  = rst_n && (dbg_cmd == DBG_IDLE);

    // One-hot to index for the debug and maintenance hit vectors.
    always_comb begin
        dbg_way = '0;
        sw_way  = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (dbg_hit[w]) dbg_way = WAY_W'(w);
            if (sw_hit[w])  sw_way  = WAY_W'(w);
        end
    end

    assign dbg_any = |dbg_hit;
    assign sw_any  = |sw_hit;

    // Debug line load: in place on a tag hit, otherwise the round-robin way.
    assign wr_en  = dbg_ok && (dbg_cmd == DBG_LOAD);
    assign wr_way = dbg_any ? dbg_way : dbg_rr;
    assign rr_adv = wr_en && !dbg_any;

    // Global clear from the debug port only.
    assign inv_all = dbg_ok && (dbg_cmd == DBG_INV_ALL);

    // Line invalidate: debug first, maintenance only when debug is idle.
    always_comb begin
        inv_en  = 1'b0;
        inv_idx = dbg_idx;
        inv_way = dbg_way;
        if (dbg_ok && (dbg_cmd == DBG_INV_LINE)) begin
            inv_en = dbg_any;
        end else if (sw_ok && (sw_op == SW_INV_LINE)) begin
            inv_en  = sw_any;
            inv_idx = sw_idx;
            inv_way = sw_way;
        end
    end

endmodule

// File: rtl/locked_icache.sv
// Module: top of the debug-loaded locked instruction cache.
// Does: splits addresses, links control, tag store and data store, and
//       registers the fetch result one cycle after the request.
// Assumes: 32-bit words; fetch addresses are word aligned, debug and
//          maintenance addresses are line aligned.
module locked_icache
    import icl_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int SETS   = 32,
    parameter int WAYS   = 2,
    parameter int WORDS  = 8
) (
    input  logic                                         clk,
    input  logic                                         rst_n,
    input  logic                                         halt_mode,
    input  logic                                         load_mode,
    input  logic                                         fetch_req,
    input  logic [ADDR_W-1:$clog2(DATA_W/8)]             fetch_waddr,
    output logic                                         fetch_vld,
    output logic                                         fetch_hit,
    output logic [DATA_W-1:0]                            fetch_data,
    input  logic [1:0]                                   dbg_cmd,
    input  logic [ADDR_W-1:$clog2(DATA_W/8)+$clog2(WORDS)] dbg_laddr,
    input  logic [WORDS*DATA_W-1:0]                      dbg_line,
    input  logic [1:0]                                   sw_op,
    input  logic [ADDR_W-1:$clog2(DATA_W/8)+$clog2(WORDS)] sw_laddr
);

    localparam int BYTE_W = $clog2(DATA_W / 8);
    localparam int OFF_W  = $clog2(WORDS);
    localparam int IDX_W  = $clog2(SETS);
    localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1;
    localparam int LINE_LSB = BYTE_W + OFF_W;
    localparam int IDX_HI   = LINE_LSB + IDX_W - 1;
    localparam int TAG_W    = ADDR_W - LINE_LSB - IDX_W;

    dbg_cmd_e dbg_cmd_e_w;
    sw_op_e   sw_op_e_w;

    logic [OFF_W-1:0] f_off;
    logic [IDX_W-1:0] f_idx, d_idx, s_idx;
    logic [TAG_W-1:0] f_tag, d_tag, s_tag;

    logic [2:0][IDX_W-1:0] q_idx;
    logic [2:0][TAG_W-1:0] q_tag;
    logic [2:0][WAYS-1:0]  q_hit;
    logic [WAYS-1:0]       fetch_way_hit;
    logic [WAY_W-1:0]      dbg_rr;

    logic             clr, wr_en, rr_adv, inv_en, inv_all;
    logic [WAY_W-1:0] wr_way, inv_way;
    logic [IDX_W-1:0] inv_idx;

    logic [SETS*WAYS-1:0]        valid_bits;
    logic [WAYS-1:0][DATA_W-1:0] way_word;
    logic [DATA_W-1:0]           sel_word;
    logic                        fetch_clash;
    logic                        lookup_hit;

    assign dbg_cmd_e_w = dbg_cmd_e'(dbg_cmd);
    assign sw_op_e_w   = sw_op_e'(sw_op);

    // Address field split for the three ports.
    assign f_off = fetch_waddr[LINE_LSB-1:BYTE_W];
    assign f_idx = fetch_waddr[IDX_HI:LINE_LSB];
    assign f_tag = fetch_waddr[ADDR_W-1:IDX_HI+1];
    assign d_idx = dbg_laddr[IDX_HI:LINE_LSB];
    assign d_tag = dbg_laddr[ADDR_W-1:IDX_HI+1];
    assign s_idx = sw_laddr[IDX_HI:LINE_LSB];
    assign s_tag = sw_laddr[ADDR_W-1:IDX_HI+1];

    assign q_idx = {s_idx, d_idx, f_idx};
    assign q_tag = {s_tag, d_tag, f_tag};
    assign fetch_way_hit = q_hit[0];

    icl_ctrl #(
        .WAYS (WAYS),
        .IDX_W(IDX_W),
        .WAY_W(WAY_W)
    ) ctrl_i (
        .rst_n  (rst_n),
        .hold   (halt_mode || load_mode),
        .dbg_cmd(dbg_cmd_e_w),
        .dbg_idx(d_idx),
        .dbg_hit(q_hit[1]),
        .dbg_rr (dbg_rr),
        .sw_op  (sw_op_e_w),
        .sw_idx (s_idx),
        .sw_hit (q_hit[2]),
        .clr    (clr),
        .wr_en  (wr_en),
        .wr_way (wr_way),
        .rr_adv (rr_adv),
        .inv_en (inv_en),
        .inv_idx(inv_idx),
        .inv_way(inv_way),
        .inv_all(inv_all)
    );

    icl_tag_store #(
        .SETS (SETS),
        .WAYS (WAYS),
        .TAG_W(TAG_W),
        .IDX_W(IDX_W),
        .WAY_W(WAY_W),
        .PORTS(3)
    ) tags_i (
        .clk       (clk),
        .clr       (clr),
        .q_idx     (q_idx),
        .q_tag     (q_tag),
        .q_hit     (q_hit),
        .q_rr      (dbg_rr),
        .wr_en     (wr_en),
        .wr_idx    (d_idx),
        .wr_way    (wr_way),
        .wr_tag    (d_tag),
        .rr_adv    (rr_adv),
        .inv_en    (inv_en),
        .inv_idx   (inv_idx),
        .inv_way   (inv_way),
        .inv_all   (inv_all),
        .valid_flat(valid_bits)
    );

    icl_data_store #(
        .SETS  (SETS),
        .WAYS  (WAYS),
        .WORDS (WORDS),
        .DATA_W(DATA_W),
        .IDX_W (IDX_W),
        .WAY_W (WAY_W),
        .OFF_W (OFF_W)
    ) data_i (
        .clk    (clk),
        .wr_en  (wr_en),
        .wr_idx (d_idx),
        .wr_way (wr_way),
        .wr_line(dbg_line),
        .rd_idx (f_idx),
        .rd_off (f_off),
        .rd_word(way_word)
    );

    // Way mux driven by the one-hot fetch hit vector.
    always_comb begin
        sel_word = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (fetch_way_hit[w]) sel_word = sel_word | way_word[w];
        end
    end

    // A debug command to the fetched set, or a global clear, wins over the lookup.
    assign fetch_clash = (dbg_cmd_e_w != DBG_IDLE) &&
                         ((dbg_cmd_e_w == DBG_INV_ALL) || (d_idx == f_idx));
    assign lookup_hit  = fetch_req && (|fetch_way_hit) && !fetch_clash;

    // Fetch result register, one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fetch_vld  <= 1'b0;
            fetch_hit  <= 1'b0;
            fetch_data <= '0;
        end else begin
            fetch_vld  <= fetch_req;
            fetch_hit  <= lookup_hit;
            fetch_data <= lookup_hit ? sel_word : '0;
        end
    end

endmodule

// File: rtl/icl_checker.sv
// Module: property checker for locked_icache, attached by bind.
// Does: checks fetch timing, the same-cycle clash rule, way uniqueness and
//       the invalidate and reset rules against the valid bits.
// Assumes: valid_bits and fetch_way_hit are the top's internal nets.
module icl_checker #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int SETS   = 32,
    parameter int WAYS   = 2,
    parameter int WORDS  = 8
) (
    input logic                                           clk,
    input logic                                           rst_n,
    input logic                                           halt_mode,
    input logic                                           load_mode,
    input logic                                           fetch_req,
    input logic [ADDR_W-1:$clog2(DATA_W/8)]               fetch_waddr,
    input logic                                           fetch_vld,
    input logic                                           fetch_hit,
    input logic [1:0]                                     dbg_cmd,
    input logic [ADDR_W-1:$clog2(DATA_W/8)+$clog2(WORDS)] dbg_laddr,
    input logic [1:0]                                     sw_op,
    input logic [SETS*WAYS-1:0]                           valid_bits,
    input logic [WAYS-1:0]                                fetch_way_hit
);

    localparam int LINE_LSB = $clog2(DATA_W / 8) + $clog2(WORDS);
    localparam int IDX_HI   = LINE_LSB + $clog2(SETS) - 1;

    logic                 started_q;
    logic                 prev_clear_q;
    logic                 prev_keep_q;
    logic [SETS*WAYS-1:0] prev_valid_q;

    // R2
    vld_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req |=> fetch_vld);

    // R2
    vld_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_req |=> !fetch_vld && !fetch_hit);

    // R10
    clash_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && dbg_cmd != 2'd0 &&
         (dbg_cmd == 2'd3 ||
          dbg_laddr[IDX_HI:LINE_LSB] == fetch_waddr[IDX_HI:LINE_LSB]))
        |=> !fetch_hit);

    // R5
    way_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fetch_way_hit));

    // R7
    sw_global_noop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_op[1] && dbg_cmd == 2'd0) |=> $stable(valid_bits));

    // R8
    dbg_clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_cmd == 2'd3) |=> (valid_bits == '0));

    // R9: reset behaviour, checked one edge after the reset cycle.
    always_ff @(posedge clk) begin
        started_q    <= 1'b1;
        prev_clear_q <= !rst_n && !(halt_mode || load_mode);
        prev_keep_q  <= !rst_n && (halt_mode || load_mode) && (dbg_cmd == 2'd0);
        prev_valid_q <= valid_bits;
        if (started_q === 1'b1 && prev_clear_q) begin
            // R9
            reset_clear_chk: assert (valid_bits == '0);
        end
        if (started_q === 1'b1 && prev_keep_q) begin
            // R9
            reset_keep_chk: assert (valid_bits == prev_valid_q);
        end
    end

endmodule

bind locked_icache icl_checker #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .SETS  (SETS),
    .WAYS  (WAYS),
    .WORDS (WORDS)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .halt_mode    (halt_mode),
    .load_mode    (load_mode),
    .fetch_req    (fetch_req),
    .fetch_waddr  (fetch_waddr),
    .fetch_vld    (fetch_vld),
    .fetch_hit    (fetch_hit),
    .dbg_cmd      (dbg_cmd),
    .dbg_laddr    (dbg_laddr),
    .sw_op        (sw_op),
    .valid_bits   (valid_bits),
    .fetch_way_hit(fetch_way_hit)
);

// File: tb/locked_icache_tb_top.sv
// Bench: table-driven stimulus for loads, invalidates and fetches, then
// directed tests for same-cycle clashes, priority and reset modes.
module locked_icache_tb_top;

    localparam int OP_FETCH = 0;
    localparam int OP_LOAD  = 1;
    localparam int OP_DINV  = 2;
    localparam int OP_DALL  = 3;
    localparam int OP_SINV  = 4;
    localparam int OP_SALL  = 5;

    localparam logic [31:0] A = 32'h0000_0040;  // set 2, tag 0
    localparam logic [31:0] B = 32'h0000_0440;  // set 2, tag 1
    localparam logic [31:0] C = 32'h0000_0840;  // set 2, tag 2
    localparam logic [31:0] D = 32'h0000_1080;  // set 4, tag 4
    localparam logic [31:0] E = 32'h0000_0C40;  // set 2, tag 3

    typedef struct packed {
        logic [2:0]  op;
        logic [31:0] addr;
        logic [7:0]  seed;
        logic        hit;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 32;
    localparam vec_t VECS [NV] = '{
        '{3'd0, A,       8'd0, 1'b0, 4'd3},  // R3 cold miss
        '{3'd0, A,       8'd0, 1'b0, 4'd3},  // R3 still miss, no allocation
        '{3'd1, A,       8'd1, 1'b0, 4'd0},  // load A -> way 0
        '{3'd0, A+4,     8'd1, 1'b1, 4'd1},  // R1 word 1
        '{3'd1, B,       8'd2, 1'b0, 4'd0},  // load B -> way 1
        '{3'd0, B+28,    8'd2, 1'b1, 4'd1},  // R1 word 7
        '{3'd0, A,       8'd1, 1'b1, 4'd4},  // R4 both held
        '{3'd1, C,       8'd3, 1'b0, 4'd0},  // load C -> way 0 (evicts A)
        '{3'd0, A,       8'd0, 1'b0, 4'd4},  // R4 A evicted
        '{3'd0, C+8,     8'd3, 1'b1, 4'd4},  // R4 C held
        '{3'd0, B,       8'd2, 1'b1, 4'd4},  // R4 B held
        '{3'd1, B,       8'd4, 1'b0, 4'd0},  // reload B in place
        '{3'd0, B+12,    8'd4, 1'b1, 4'd5},  // R5 new data
        '{3'd1, A,       8'd5, 1'b0, 4'd0},  // pointer still 1 -> evicts B
        '{3'd0, B,       8'd0, 1'b0, 4'd5},  // R5 B evicted
        '{3'd0, C,       8'd3, 1'b1, 4'd5},  // R5 C kept
        '{3'd5, A,       8'd0, 1'b0, 4'd0},  // sw global invalidate
        '{3'd0, C,       8'd3, 1'b1, 4'd7},  // R7
        '{3'd0, A+16,    8'd5, 1'b1, 4'd7},  // R7
        '{3'd4, E,       8'd0, 1'b0, 4'd0},  // sw line invalidate, miss
        '{3'd0, A,       8'd5, 1'b1, 4'd6},  // R6 no effect
        '{3'd0, C,       8'd3, 1'b1, 4'd6},  // R6 no effect
        '{3'd4, A,       8'd0, 1'b0, 4'd0},  // sw line invalidate, hit
        '{3'd0, A,       8'd0, 1'b0, 4'd6},  // R6 cleared
        '{3'd0, C,       8'd3, 1'b1, 4'd6},  // R6 other way kept
        '{3'd1, D,       8'd6, 1'b0, 4'd0},  // load D in set 4
        '{3'd0, D+8,     8'd6, 1'b1, 4'd1},  // R1
        '{3'd2, C,       8'd0, 1'b0, 4'd0},  // debug line invalidate C
        '{3'd0, C,       8'd0, 1'b0, 4'd8},  // R8
        '{3'd0, D,       8'd6, 1'b1, 4'd8},  // R8 other line kept
        '{3'd3, A,       8'd0, 1'b0, 4'd0},  // debug clear all
        '{3'd0, D,       8'd0, 1'b0, 4'd8}   // R8
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         halt_mode = 1'b0;
    logic         load_mode = 1'b0;
    logic         fetch_req = 1'b0;
    logic [31:2]  fetch_waddr = '0;
    logic         fetch_vld;
    logic         fetch_hit;
    logic [31:0]  fetch_data;
    logic [1:0]   dbg_cmd = 2'd0;
    logic [31:5]  dbg_laddr = '0;
    logic [255:0] dbg_line = '0;
    logic [1:0]   sw_op = 2'd0;
    logic [31:5]  sw_laddr = '0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    locked_icache dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .halt_mode  (halt_mode),
        .load_mode  (load_mode),
        .fetch_req  (fetch_req),
        .fetch_waddr(fetch_waddr),
        .fetch_vld  (fetch_vld),
        .fetch_hit  (fetch_hit),
        .fetch_data (fetch_data),
        .dbg_cmd    (dbg_cmd),
        .dbg_laddr  (dbg_laddr),
        .dbg_line   (dbg_line),
        .sw_op      (sw_op),
        .sw_laddr   (sw_laddr)
    );

    function automatic logic [31:0] wpat(input logic [31:0] a, input logic [7:0] s);
        return {s, 8'h3C ^ s, a[15:0]};
    endfunction

    function automatic logic [255:0] line_of(input logic [31:0] a, input logic [7:0] s);
        logic [255:0] l;
        for (int w = 0; w < 8; w++) l[32*w +: 32] = wpat({a[31:5], 3'(w), 2'b00}, s);
        return l;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Start the debug command; the caller ends it at the next falling edge.
    task automatic dbg_start(input logic [1:0] cmd, input logic [31:0] a, input logic [7:0] s);
        dbg_cmd   = cmd;
        dbg_laddr = a[31:5];
        dbg_line  = line_of(a, s);
    endtask

    task automatic idle_all();
        dbg_cmd   = 2'd0;
        sw_op     = 2'd0;
        fetch_req = 1'b0;
    endtask

    // Fetch and compare one cycle later.
    task automatic fetch_chk(input logic [31:0] a, input bit eh, input logic [7:0] s,
                             input string req);
        logic [31:0] ed;
        fetch_req   = 1'b1;
        fetch_waddr = a[31:2];
        @(negedge clk);
        idle_all();
        ed = eh ? wpat(a, s) : 32'h0;
        check(fetch_vld === 1'b1, req, {31'b0, fetch_vld}, 32'h1);
        check(fetch_hit === eh, req, {31'b0, fetch_hit}, {31'b0, eh});
        check(fetch_data === ed, req, fetch_data, ed);
    endtask

    task automatic op_cycle(input int op, input logic [31:0] a, input logic [7:0] s);
        case (op)
            OP_LOAD: dbg_start(2'd1, a, s);
            OP_DINV: dbg_start(2'd2, a, s);
            OP_DALL: dbg_start(2'd3, a, s);
            OP_SINV: begin sw_op = 2'd1; sw_laddr = a[31:5]; end
            OP_SALL: begin sw_op = 2'd2; sw_laddr = a[31:5]; end
            default: ;
        endcase
        @(negedge clk);
        idle_all();
    endtask

    task automatic do_reset(input bit h, input bit l);
        halt_mode = h;
        load_mode = l;
        rst_n     = 1'b0;
        @(negedge clk);
        // Reset state of the fetch result (R2 outputs idle during reset).
        check(fetch_vld === 1'b0 && fetch_hit === 1'b0 && fetch_data === 32'h0,
              "R9 reset outputs", {fetch_vld, fetch_hit, fetch_data[29:0]}, 32'h0);
    endtask

    task automatic end_reset();
        @(negedge clk);
        rst_n     = 1'b1;
        halt_mode = 1'b0;
        load_mode = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset(1'b0, 1'b0);
        end_reset();

        // Table walk.
        for (int i = 0; i < NV; i++) begin
            if (VECS[i].op == 3'(OP_FETCH))
                fetch_chk(VECS[i].addr, VECS[i].hit, VECS[i].seed,
                          $sformatf("R%0d vec %0d", VECS[i].req, i));
            else
                op_cycle(int'(VECS[i].op), VECS[i].addr, VECS[i].seed);
        end

        // R10: load and fetch to the same set in one cycle -> miss, then hit.
        dbg_start(2'd1, D, 8'd9);
        fetch_chk(D, 1'b0, 8'd0, "R10 same-set clash");
        fetch_chk(D, 1'b1, 8'd9, "R10 load completed");

        // R10: load to set 2 while fetching set 4 -> unaffected hit.
        dbg_start(2'd1, A, 8'd7);
        fetch_chk(D + 4, 1'b1, 8'd9, "R10 other set");
        fetch_chk(A, 1'b1, 8'd7, "R4 load after clash");

        // R11: debug invalidate (missing) with sw invalidate of A -> A kept.
        dbg_start(2'd2, 32'h0000_3000, 8'd0);
        sw_op    = 2'd1;
        sw_laddr = A[31:5];
        @(negedge clk);
        idle_all();
        fetch_chk(A, 1'b1, 8'd7, "R11 sw dropped under debug");

        // R2: no request -> no valid result.
        @(negedge clk);
        check(fetch_vld === 1'b0, "R2 idle", {31'b0, fetch_vld}, 32'h0);

        // R9: reset in halt mode keeps contents.
        do_reset(1'b1, 1'b0);
        end_reset();
        fetch_chk(A, 1'b1, 8'd7, "R9 halt keeps");

        // R12: debug load during reset in load mode; R11 sw in reset ignored.
        do_reset(1'b0, 1'b1);
        dbg_start(2'd1, C, 8'd8);
        sw_op    = 2'd1;
        sw_laddr = D[31:5];
        @(negedge clk);
        idle_all();
        end_reset();
        fetch_chk(C, 1'b1, 8'd8, "R12 load in reset");
        fetch_chk(A, 1'b1, 8'd7, "R9 load mode keeps");
        fetch_chk(D, 1'b1, 8'd9, "R11 sw in reset ignored");

        // R9: plain reset clears everything.
        do_reset(1'b0, 1'b0);
        end_reset();
        fetch_chk(A, 1'b0, 8'd0, "R9 cleared A");
        fetch_chk(C, 1'b0, 8'd0, "R9 cleared C");

        // R4: pointer reset to way 0 -> two loads fill both ways of set 2.
        op_cycle(OP_LOAD, B, 8'd10);
        op_cycle(OP_LOAD, E, 8'd11);
        op_cycle(OP_LOAD, C, 8'd12);
        fetch_chk(B, 1'b0, 8'd0, "R4 third load evicts first");
        fetch_chk(E, 1'b1, 8'd11, "R4 second kept");

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule